// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block merges the pending interrupt sources of a UART into one interrupt line and one identification byte for the CPU. The sources are line-status error, received data available, receive timeout, transmit holding empty and modem status. Each source is gated by its interrupt enable bit. The enabled pending sources are ranked by a fixed priority, and the winner's code is what the CPU reads.

A read strobe latches the identification byte, so one read returns one consistent code. When that code is the transmit-empty one, the read also sends a one-cycle clear to the transmit-empty source. With FIFO mode on, clearing a direction's enables puts that direction into polled mode, and the block reports this. In receive polled mode it also reports whether the receive FIFO holds data.

Top module: `uart_irq_ident`

## Requirements
- R1: During and after reset, before any stimulus: `iid_o` = 01h, and `irq_o`, `thre_clr_o`, `rx_poll_o`, `tx_poll_o` and `rx_ready_o` are all 0.
- R2: With no enabled source pending, the live code is 1h and `irq_o` is 0. `irq_o` goes high one cycle after any enabled source is pending.
- R3: Line-status pending with enable bit 2 set gives code 6h. This code wins over every other source.
- R4: Receive data available with enable bit 0 set gives code 4h. Receive timeout uses the same level and the same enable bit, and gives code Ch. Timeout counts only when data available is not pending and `fifo_en_i` is 1. With `fifo_en_i` at 0, timeout is ignored.
- R5: Transmit holding empty with enable bit 1 set gives code 2h. It ranks below the receive level.
- R6: Modem status with enable bit 3 set gives code 0h. It has the lowest priority.
- R7: A pending source whose enable bit is 0 has no effect on `irq_o` or on the code read.
- R8: On a clock edge with `iid_rd_i` high, `iid_o` latches {2{fifo_en}}, 2'b00, code, using the code settled at that edge. It holds between strobes.
- R9: `thre_clr_o` pulses for exactly one cycle, in the cycle `iid_o` updates, only when the latched code is 2h.
- R10: `rx_poll_o` is 1 one cycle after `fifo_en_i`=1 with enable bits 0 and 2 both 0. `tx_poll_o` is 1 one cycle after `fifo_en_i`=1 with enable bit 1 at 0.
- R11: `rx_ready_o` is 1 one cycle after the receive direction is in polled mode and `rx_count_i` is nonzero. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enabled |
| ier_i | input | 4 | Enables: [0] receive, [1] transmit empty, [2] line status, [3] modem |
| ls_pend_i | input | 1 | Line-status error pending |
| rda_pend_i | input | 1 | Received data available pending |
| rx_to_pend_i | input | 1 | Receive timeout pending |
| thre_pend_i | input | 1 | Transmit holding empty pending |
| ms_pend_i | input | 1 | Modem status pending |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| iid_rd_i | input | 1 | Identification read strobe |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 8 | Latched identification byte |
| thre_clr_o | output | 1 | Clear pulse to the transmit-empty source |
| rx_poll_o | output | 1 | Receive direction in polled mode |
| tx_poll_o | output | 1 | Transmit direction in polled mode |
| rx_ready_o | output | 1 | Polled-mode receive data ready |

## Verification
The live code, `irq_o` and the three polled-mode outputs are each one register past the inputs, so they are due one cycle after a change. `iid_o` and `thre_clr_o` update at the edge where the strobe is high, and `thre_clr_o` must fall again one cycle later. The bench drives every input on the falling edge and first holds the sources steady for a full cycle. It then samples on the next falling edge, and only after that raises the strobe for one cycle. It checks the latched byte and the clear pulse on the falling edge after the strobe edge, and checks that both hold or drop one cycle after that.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_MS   = 4'h0,
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RDA  = 4'h4,
    IID_LS   = 4'h6,
    IID_TO   = 4'hC
  } iid_code_e;

  localparam int unsigned NSRC  = 5;
  localparam int unsigned IER_W = 4;
  localparam int unsigned IID_W = 8;

  // source index order is the priority order, 0 highest
  localparam int unsigned SRC_LS   = 0;
  localparam int unsigned SRC_RDA  = 1;
  localparam int unsigned SRC_TO   = 2;
  localparam int unsigned SRC_THRE = 3;
  localparam int unsigned SRC_MS   = 4;

  localparam int unsigned EN_RX = 0;
  localparam int unsigned EN_TX = 1;
  localparam int unsigned EN_LS = 2;
  localparam int unsigned EN_MS = 3;

  function automatic int unsigned en_bit_of(input int unsigned s);
    case (s)
      SRC_LS:   return EN_LS;
      SRC_THRE: return EN_TX;
      SRC_MS:   return EN_MS;
      default:  return EN_RX;
    endcase
  endfunction

  function automatic logic needs_fifo(input int unsigned s);
    return s == SRC_TO;
  endfunction

  function automatic iid_code_e code_of(input int unsigned s);
    case (s)
      SRC_LS:   return IID_LS;
      SRC_RDA:  return IID_RDA;
      SRC_TO:   return IID_TO;
      SRC_THRE: return IID_THRE;
      default:  return IID_MS;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0]  src_i,
  input  logic [IER_W-1:0] ier_i,
  input  logic             fifo_en_i,
  output logic [NSRC-1:0]  src_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int unsigned EB = en_bit_of(g);
    if (needs_fifo(g)) begin : g_fifo
      assign src_o[g] = src_i[g] & ier_i[EB] & fifo_en_i;
    end else begin : g_plain
      assign src_o[g] = src_i[g] & ier_i[EB];
    end
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] src_i,
  output iid_code_e       code_o
);

  // scan lowest to highest so the highest pending wins
  always_comb begin
    code_o = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_i[i]) code_o = code_of(i);
    end
  end

endmodule

// File: rtl/uart_irq_capture.sv
module uart_irq_capture
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  iid_code_e        code_i,
  input  logic             fifo_en_i,
  input  logic             rd_i,
  output logic             irq_o,
  output logic [IID_W-1:0] iid_o,
  output logic             thre_clr_o
);

  iid_code_e code_q;
  logic      fifo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= IID_NONE;
      fifo_q <= 1'b0;
    end else begin
      code_q <= code_i;
      fifo_q <= fifo_en_i;
    end
  end

  assign irq_o = ~code_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iid_o      <= {{(IID_W-4){1'b0}}, IID_NONE};
      thre_clr_o <= 1'b0;
    end else begin
      thre_clr_o <= rd_i && (code_q == IID_THRE);
      if (rd_i) iid_o <= {{2{fifo_q}}, {(IID_W-6){1'b0}}, code_q};
    end
  end

endmodule

// File: rtl/uart_irq_poll.sv
module uart_irq_poll
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [IER_W-1:0] ier_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             rx_poll_o,
  output logic             tx_poll_o,
  output logic             rx_ready_o
);

  logic rx_poll_d, tx_poll_d;

  assign rx_poll_d = fifo_en_i & ~ier_i[EN_RX] & ~ier_i[EN_LS];
  assign tx_poll_d = fifo_en_i & ~ier_i[EN_TX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_poll_o  <= 1'b0;
      tx_poll_o  <= 1'b0;
      rx_ready_o <= 1'b0;
    end else begin
      rx_poll_o  <= rx_poll_d;
      tx_poll_o  <= tx_poll_d;
      rx_ready_o <= rx_poll_d & (|rx_count_i);
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [3:0]       ier_i,
  input  logic             ls_pend_i,
  input  logic             rda_pend_i,
  input  logic             rx_to_pend_i,
  input  logic             thre_pend_i,
  input  logic             ms_pend_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             iid_rd_i,
  output logic             irq_o,
  output logic [7:0]       iid_o,
  output logic             thre_clr_o,
  output logic             rx_poll_o,
  output logic             tx_poll_o,
  output logic             rx_ready_o
);

  logic [NSRC-1:0] src_raw, src_en;
  iid_code_e       code_live;

  always_comb begin
    src_raw           = '0;
    src_raw[SRC_LS]   = ls_pend_i;
    src_raw[SRC_RDA]  = rda_pend_i;
    src_raw[SRC_TO]   = rx_to_pend_i;
    src_raw[SRC_THRE] = thre_pend_i;
    src_raw[SRC_MS]   = ms_pend_i;
  end

  uart_irq_gate i_gate (
    .src_i     (src_raw),
    .ier_i     (ier_i),
    .fifo_en_i (fifo_en_i),
    .src_o     (src_en)
  );

  uart_irq_prio i_prio (
    .src_i  (src_en),
    .code_o (code_live)
  );

  uart_irq_capture i_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (code_live),
    .fifo_en_i  (fifo_en_i),
    .rd_i       (iid_rd_i),
    .irq_o      (irq_o),
    .iid_o      (iid_o),
    .thre_clr_o (thre_clr_o)
  );

  uart_irq_poll #(.CNT_W(CNT_W)) i_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .ier_i      (ier_i),
    .rx_count_i (rx_count_i),
    .rx_poll_o  (rx_poll_o),
    .tx_poll_o  (tx_poll_o),
    .rx_ready_o (rx_ready_o)
  );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic [3:0]       ier_i,
  input logic             ls_pend_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic             iid_rd_i,
  input logic             irq_o,
  input logic [7:0]       iid_o,
  input logic             thre_clr_o,
  input logic             tx_poll_o,
  input logic             rx_ready_o
);

  assert_ls_raises_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i[2] && ls_pend_i) |=> irq_o);

  assert_read_matches_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_rd_i && rst_ni) |=> (iid_o[0] == !$past(irq_o)));

  assert_iid_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iid_rd_i |=> $stable(iid_o));

  assert_clr_only_on_thre_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_clr_o |-> (iid_o[3:0] == 4'h2));

  assert_clr_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_clr_o |=> !thre_clr_o || $past(iid_rd_i));

  assert_tx_poll_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && !ier_i[1]) |=> tx_poll_o);

  assert_ready_needs_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_o && rst_ni) |-> $past(|rx_count_i));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .ier_i      (ier_i),
  .ls_pend_i  (ls_pend_i),
  .rx_count_i (rx_count_i),
  .iid_rd_i   (iid_rd_i),
  .irq_o      (irq_o),
  .iid_o      (iid_o),
  .thre_clr_o (thre_clr_o),
  .tx_poll_o  (tx_poll_o),
  .rx_ready_o (rx_ready_o)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

  localparam int unsigned CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fifo_en_i = 1'b0;
  logic [3:0]       ier_i = '0;
  logic             ls_pend_i = 1'b0, rda_pend_i = 1'b0, rx_to_pend_i = 1'b0;
  logic             thre_pend_i = 1'b0, ms_pend_i = 1'b0;
  logic [CNT_W-1:0] rx_count_i = '0;
  logic             iid_rd_i = 1'b0;
  logic             irq_o, thre_clr_o, rx_poll_o, tx_poll_o, rx_ready_o;
  logic [7:0]       iid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) i_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .ier_i(ier_i),
    .ls_pend_i(ls_pend_i), .rda_pend_i(rda_pend_i), .rx_to_pend_i(rx_to_pend_i),
    .thre_pend_i(thre_pend_i), .ms_pend_i(ms_pend_i), .rx_count_i(rx_count_i),
    .iid_rd_i(iid_rd_i), .irq_o(irq_o), .iid_o(iid_o), .thre_clr_o(thre_clr_o),
    .rx_poll_o(rx_poll_o), .tx_poll_o(tx_poll_o), .rx_ready_o(rx_ready_o)
  );

  function automatic logic [3:0] ref_code(input logic [3:0] ier, input logic fe,
      input logic ls, input logic rda, input logic to, input logic thre, input logic ms);
    if (ier[2] && ls) return 4'h6;
    if (ier[0] && rda) return 4'h4;
    if (ier[0] && to && fe) return 4'hC;
    if (ier[1] && thre) return 4'h2;
    if (ier[3] && ms) return 4'h0;
    return 4'h1;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h6: return "R3";
      4'h4, 4'hC: return "R4";
      4'h2: return "R5";
      4'h0: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive, settle one cycle, check live results, optionally strobe a read
  task automatic step(input logic [3:0] ier, input logic fe, input logic ls,
      input logic rda, input logic to, input logic thre, input logic ms,
      input logic [CNT_W-1:0] cnt, input logic do_read, input string tag);
    logic [3:0] c;
    logic [7:0] e_iid;
    logic       rxp, txp;
    @(negedge clk);
    ier_i = ier; fifo_en_i = fe; ls_pend_i = ls; rda_pend_i = rda;
    rx_to_pend_i = to; thre_pend_i = thre; ms_pend_i = ms; rx_count_i = cnt;
    iid_rd_i = 1'b0;
    c   = ref_code(ier, fe, ls, rda, to, thre, ms);
    rxp = fe & ~ier[0] & ~ier[2];
    txp = fe & ~ier[1];
    @(negedge clk);
    check(irq_o == (c != 4'h1), (tag != "") ? tag : tag_of(c), irq_o, c != 4'h1);
    check(rx_poll_o == rxp && tx_poll_o == txp, "R10", {rx_poll_o, tx_poll_o}, {rxp, txp});
    check(rx_ready_o == (rxp && cnt != 0), "R11", rx_ready_o, rxp && cnt != 0);
    if (do_read) begin
      e_iid = {{2{fe}}, 2'b00, c};
      iid_rd_i = 1'b1;
      @(negedge clk);
      iid_rd_i = 1'b0;
      check(iid_o == e_iid, (tag != "") ? tag : tag_of(c), iid_o, e_iid);
      check(thre_clr_o == (c == 4'h2), "R9", thre_clr_o, c == 4'h2);
      @(negedge clk);
      check(thre_clr_o == 1'b0, "R9", thre_clr_o, 0);
      check(iid_o == e_iid, "R8", iid_o, e_iid);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(iid_o == 8'h01 && !irq_o && !thre_clr_o, "R1", {irq_o, thre_clr_o, iid_o}, 8'h01);
    check(!rx_poll_o && !tx_poll_o && !rx_ready_o, "R1", {rx_poll_o, tx_poll_o, rx_ready_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(iid_o == 8'h01 && !irq_o, "R1", iid_o, 8'h01);

    // directed corners
    step(4'h0, 1, 0, 0, 0, 0, 0, 0, 1, "R2");     // nothing pending
    step(4'hF, 1, 1, 1, 1, 1, 1, 3, 1, "R3");     // line status wins
    step(4'hB, 1, 1, 1, 1, 1, 1, 3, 1, "R7");     // ls disabled -> rda
    step(4'h1, 1, 0, 1, 1, 0, 0, 0, 1, "R4");     // rda over timeout
    step(4'h1, 1, 0, 0, 1, 0, 0, 0, 1, "R4");     // timeout 0Ch
    step(4'h1, 0, 0, 0, 1, 0, 0, 0, 1, "R4");     // timeout ignored, FIFO off
    step(4'hA, 1, 0, 0, 1, 1, 1, 0, 1, "R5");     // rx disabled -> thre, clear pulse
    step(4'h8, 0, 1, 1, 1, 1, 1, 0, 1, "R6");     // modem only, fifo bits 00
    step(4'h0, 1, 1, 1, 1, 1, 1, 2, 1, "R7");     // all disabled
    step(4'h0, 1, 0, 0, 0, 0, 0, 0, 0, "R11");    // polled, empty
    step(4'h0, 1, 0, 0, 0, 0, 0, 7, 0, "R11");    // polled, data
    step(4'h4, 1, 0, 0, 0, 0, 0, 7, 0, "R10");    // ls enabled: rx not polled

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0], r[4], r[5], r[6], r[7], r[8], r[9],
           (r[12:10] == 0) ? '0 : CNT_W'(r[15:13]), r[16] | r[17], "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule